// File: doc/BRIEF.md
# Temperature Sensor Register Bank with Write Locks

This block holds the eight 16-bit registers of an on-die temperature monitor behind a small pointer-based host port. The host first loads a 3-bit pointer, then writes or reads the register it selects. A read returns the selected register at once as a combinational word. A write takes effect at the next clock edge. The pointer is loaded at the same edge, and a write in that cycle goes to the register the pointer selected before the load.

Each register is one of four kinds: a fixed identity value, the configuration word, one of the three limit values, or the latest temperature word delivered by the converter. The block passes the configuration fields, the three limits and the stored temperature to the external event logic. It takes back the event status bit for read-back. Two sticky lock bits in the configuration word guard the limits and most of the configuration fields. Only the block reset, which stands for power-on reset, clears them.

Top module: `tsense_regbank`

## Requirements
- R1: After reset the pointer is 0. The fixed registers read as follows: address 0 capability = 0x007F, address 6 manufacturer = 0x1B09, address 7 device/revision = 0x2230. The configuration word and the three limits (addresses 1, 2, 3, 4) read 0x0000.
- R2: Host writes to addresses 0, 5, 6 and 7 are ignored. Their read values do not change.
- R3: In the configuration word (address 1), bits 15:11 and bit 5 always read 0. Bit 4 reads the `evt_status` input.
- R4: A write to address 1 with bit 5 set makes `evt_clear` high for exactly the one cycle after the write edge. No other write produces the pulse.
- R5: The configuration lock bits are bit 6 (alarm lock) and bit 7 (critical lock). A write of 1 sets them. Once set, writing 0 does not clear them; only reset does.
- R6: While the alarm lock is set, writes to the high limit (address 2) and the low limit (address 3) are ignored. While the critical lock is set, writes to the critical limit (address 4) are ignored. Otherwise a write stores the full 16-bit word.
- R7: While either lock is set, configuration writes do not change these fields: hysteresis (bits 10:9), event enable (bit 3), polarity (bit 1) and mode (bit 0).
- R8: While either lock is set, the shutdown bit (bit 8) can be cleared but not set.
- R9: While the alarm lock is set, the critical-only bit (bit 2) can be cleared but not set. Under the critical lock alone it can still be written freely.
- R10: The temperature register (address 5) loads `conv_word` at an edge where `conv_valid` is high and shutdown is clear. While shutdown is set it keeps its value.
- R11: A pointer load makes later reads return the register at the loaded address. The exported fields and limits always equal the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| ptr_load | input | 1 | Load the register pointer from `ptr_in` |
| ptr_in | input | 3 | New pointer value |
| wr_en | input | 1 | Write `wr_data` to the selected register |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Selected register contents |
| evt_status | input | 1 | Event output state from the event logic |
| conv_valid | input | 1 | Converter result strobe |
| conv_word | input | 16 | Converter result word |
| hyst_sel | output | 2 | Hysteresis selection |
| shdn | output | 1 | Sensor shutdown |
| evt_enable | output | 1 | Event output enable |
| crit_only | output | 1 | Event on critical limit only |
| evt_pol | output | 1 | Event polarity, 1 = active high |
| evt_mode | output | 1 | 0 = comparator, 1 = interrupt |
| evt_clear | output | 1 | One-cycle event clear pulse |
| lim_high | output | 16 | High alarm limit |
| lim_low | output | 16 | Low alarm limit |
| lim_crit | output | 16 | Critical limit |
| temp_word | output | 16 | Stored temperature word |

## Verification
Assertions check the following on every cycle:
- The locks never fall while reset is released.
- A locked limit never moves.
- The locked configuration fields stay stable.
- Shutdown and critical-only never rise under their locks.
- The temperature register stays frozen during shutdown.
- The reserved and clear bits read zero.

Only the bench scenarios can show the rest:
- Writes are actually accepted when no lock is set.
- The pointer ordering between loads and writes.
- The exact value of each identity register.
- The width and timing of the clear pulse.
- A lock set in the same write as other fields still lets those fields through.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
   localparam int REG_W    = 16;
   localparam int NUM_REGS = 8;
   localparam int PTR_W    = $clog2(NUM_REGS);
   localparam int NUM_LIM  = 3;

   typedef enum logic [PTR_W-1:0] {
      ADR_CAP  = 3'd0,
      ADR_CFG  = 3'd1,
      ADR_HIGH = 3'd2,
      ADR_LOW  = 3'd3,
      ADR_CRIT = 3'd4,
      ADR_TEMP = 3'd5,
      ADR_MFR  = 3'd6,
      ADR_DEV  = 3'd7
   } reg_addr_e;

   // configuration word bit positions
   localparam int B_MODE  = 0;
   localparam int B_POL   = 1;
   localparam int B_CONLY = 2;
   localparam int B_EVEN  = 3;
   localparam int B_STS   = 4;
   localparam int B_CLR   = 5;
   localparam int B_LKA   = 6;
   localparam int B_LKC   = 7;
   localparam int B_SHDN  = 8;
   localparam int B_HYLO  = 9;
   localparam int B_HYHI  = 10;

   typedef struct packed {
      logic [1:0] hyst;
      logic       shdn;
      logic       lock_crit;
      logic       lock_alarm;
      logic       evt_en;
      logic       crit_only;
      logic       pol;
      logic       mode;
   } cfg_t;
endpackage

// File: rtl/tsense_cfg.sv
module tsense_cfg
   import tsense_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_cfg,
   input  logic [W-1:0] wd,
   output cfg_t         cfg_q,
   output logic         clr_pulse
);
   generate
      if (W < B_HYHI + 1) begin : g_bad_width
         $error("tsense_cfg: W too small for the configuration layout");
      end
   endgenerate

   cfg_t cfg_d;
   logic any_lock;
   logic unused_wd;

   assign unused_wd = ^{wd[W-1:B_HYHI+1], wd[B_STS]};
   assign any_lock  = cfg_q.lock_crit | cfg_q.lock_alarm;

   always_comb begin
      cfg_d            = cfg_q;
      cfg_d.lock_crit  = cfg_q.lock_crit  | wd[B_LKC];
      cfg_d.lock_alarm = cfg_q.lock_alarm | wd[B_LKA];
      if (!any_lock) begin
         cfg_d.hyst   = wd[B_HYHI:B_HYLO];
         cfg_d.shdn   = wd[B_SHDN];
         cfg_d.evt_en = wd[B_EVEN];
         cfg_d.pol    = wd[B_POL];
         cfg_d.mode   = wd[B_MODE];
      end else begin
         cfg_d.shdn   = cfg_q.shdn & wd[B_SHDN];
      end
      cfg_d.crit_only = cfg_q.lock_alarm ? (cfg_q.crit_only & wd[B_CONLY]) : wd[B_CONLY];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         clr_pulse <= 1'b0;
      end else begin
         clr_pulse <= wr_cfg & wd[B_CLR];
         if (wr_cfg) cfg_q <= cfg_d;
      end
   end

   assert_lock_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock_alarm |=> cfg_q.lock_alarm);
   assert_lock_crit_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock_crit |=> cfg_q.lock_crit);
   assert_locked_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any_lock |=> $stable({cfg_q.hyst, cfg_q.evt_en, cfg_q.pol, cfg_q.mode}));
   assert_shdn_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lock && !cfg_q.shdn) |=> !cfg_q.shdn);
   assert_conly_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.lock_alarm && !cfg_q.crit_only) |=> !cfg_q.crit_only);
   assert_clear_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg |=> !clr_pulse);
endmodule

// File: rtl/tsense_limits.sv
module tsense_limits
   import tsense_pkg::*;
#(
   parameter int W = REG_W,
   parameter int N = NUM_LIM
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        wr_lim,
   input  logic [N-1:0]        lock_v,
   input  logic [W-1:0]        wd,
   output logic [N-1:0][W-1:0] lim_q
);
   generate
      if (N < 1) begin : g_bad_count
         $error("tsense_limits: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_lim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       lim_q[i] <= '0;
            else if (wr_lim[i] && !lock_v[i]) lim_q[i] <= wd;
         end

         assert_lim_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[i] |=> $stable(lim_q[i]));
      end
   endgenerate
endmodule

// File: rtl/tsense_temp.sv
module tsense_temp
   import tsense_pkg::*;
#(
   parameter int           W         = REG_W,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_vld,
   input  logic [W-1:0] smp,
   input  logic         frozen,
   output logic [W-1:0] temp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  temp_q <= RESET_VAL;
      else if (smp_vld && !frozen) temp_q <= smp;
   end

   assert_frozen_in_shdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(temp_q));
endmodule

// File: rtl/tsense_regbank.sv
module tsense_regbank
   import tsense_pkg::*;
#(
   parameter int                DATA_W    = REG_W,
   parameter logic [DATA_W-1:0] CAP_VAL   = 16'h007F,
   parameter logic [DATA_W-1:0] MFR_VAL   = 16'h1B09,
   parameter logic [DATA_W-1:0] DEV_VAL   = 16'h2230,
   parameter logic [DATA_W-1:0] TEMP_INIT = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_load,
   input  logic [PTR_W-1:0]  ptr_in,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              evt_status,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_word,
   output logic [1:0]        hyst_sel,
   output logic              shdn,
   output logic              evt_enable,
   output logic              crit_only,
   output logic              evt_pol,
   output logic              evt_mode,
   output logic              evt_clear,
   output logic [DATA_W-1:0] lim_high,
   output logic [DATA_W-1:0] lim_low,
   output logic [DATA_W-1:0] lim_crit,
   output logic [DATA_W-1:0] temp_word
);
   localparam int LIM_BASE = int'(ADR_HIGH);

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("tsense_regbank: DATA_W must equal REG_W");
      end
      if (LIM_BASE + NUM_LIM > NUM_REGS) begin : g_bad_map
         $error("tsense_regbank: limit block exceeds the register map");
      end
   endgenerate

   reg_addr_e                   ptr_q;
   cfg_t                        cfg;
   logic [NUM_LIM-1:0]          wr_lim;
   logic [NUM_LIM-1:0]          lock_v;
   logic [NUM_LIM-1:0][DATA_W-1:0] lim;
   logic [DATA_W-1:0]           cfg_word;
   logic                        wr_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= ADR_CAP;
      else if (ptr_load) ptr_q <= reg_addr_e'(ptr_in);
   end

   assign wr_cfg = wr_en && (ptr_q == ADR_CFG);

   generate
      for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim_dec
         assign wr_lim[i] = wr_en && (int'(ptr_q) == LIM_BASE + i);
         // the last limit is the critical one; the others are alarm limits
         if (i == NUM_LIM - 1) begin : g_crit
            assign lock_v[i] = cfg.lock_crit;
         end else begin : g_alarm
            assign lock_v[i] = cfg.lock_alarm;
         end
      end
   endgenerate

   tsense_cfg #(.W(DATA_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cfg   (wr_cfg),
      .wd       (wr_data),
      .cfg_q    (cfg),
      .clr_pulse(evt_clear)
   );

   tsense_limits #(.W(DATA_W), .N(NUM_LIM)) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lim(wr_lim),
      .lock_v(lock_v),
      .wd    (wr_data),
      .lim_q (lim)
   );

   tsense_temp #(.W(DATA_W), .RESET_VAL(TEMP_INIT)) u_temp (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_vld(conv_valid),
      .smp    (conv_word),
      .frozen (cfg.shdn),
      .temp_q (temp_word)
   );

   always_comb begin
      cfg_word                   = '0;
      cfg_word[B_HYHI:B_HYLO]    = cfg.hyst;
      cfg_word[B_SHDN]           = cfg.shdn;
      cfg_word[B_LKC]            = cfg.lock_crit;
      cfg_word[B_LKA]            = cfg.lock_alarm;
      cfg_word[B_STS]            = evt_status;
      cfg_word[B_EVEN]           = cfg.evt_en;
      cfg_word[B_CONLY]          = cfg.crit_only;
      cfg_word[B_POL]            = cfg.pol;
      cfg_word[B_MODE]           = cfg.mode;
   end

   always_comb begin
      unique case (ptr_q)
         ADR_CAP:  rd_data = CAP_VAL;
         ADR_CFG:  rd_data = cfg_word;
         ADR_HIGH: rd_data = lim[0];
         ADR_LOW:  rd_data = lim[1];
         ADR_CRIT: rd_data = lim[2];
         ADR_TEMP: rd_data = temp_word;
         ADR_MFR:  rd_data = MFR_VAL;
         ADR_DEV:  rd_data = DEV_VAL;
         default:  rd_data = '0;
      endcase
   end

   assign hyst_sel   = cfg.hyst;
   assign shdn       = cfg.shdn;
   assign evt_enable = cfg.evt_en;
   assign crit_only  = cfg.crit_only;
   assign evt_pol    = cfg.pol;
   assign evt_mode   = cfg.mode;
   assign lim_high   = lim[0];
   assign lim_low    = lim[1];
   assign lim_crit   = lim[2];

   assert_cfg_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q == ADR_CFG) |-> (rd_data[DATA_W-1:B_HYHI+1] == '0 && !rd_data[B_CLR]));
   assert_fixed_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q == ADR_MFR) |-> (rd_data == MFR_VAL));
endmodule

// File: tb/test_tsense_regbank.sv
module test_tsense_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_load = 1'b0;
   logic [2:0]  ptr_in = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        evt_status = 1'b0;
   logic        conv_valid = 1'b0;
   logic [15:0] conv_word = '0;
   logic [1:0]  hyst_sel;
   logic        shdn, evt_enable, crit_only, evt_pol, evt_mode, evt_clear;
   logic [15:0] lim_high, lim_low, lim_crit, temp_word;

   always #10 clk = ~clk;   // 50 MHz

   tsense_regbank i_tsense_regbank (
      .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_in(ptr_in),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .evt_status(evt_status), .conv_valid(conv_valid), .conv_word(conv_word),
      .hyst_sel(hyst_sel), .shdn(shdn), .evt_enable(evt_enable),
      .crit_only(crit_only), .evt_pol(evt_pol), .evt_mode(evt_mode),
      .evt_clear(evt_clear), .lim_high(lim_high), .lim_low(lim_low),
      .lim_crit(lim_crit), .temp_word(temp_word)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference model
   int          m_ptr;
   int          m_hyst;
   bit          m_shdn, m_lc, m_la, m_en, m_co, m_pol, m_mode, m_clr;
   logic [15:0] m_hi, m_lo, m_cr, m_temp;

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] model_rd();
      logic [15:0] c;
      c = 16'(m_hyst << 9) | 16'(m_shdn << 8) | 16'(m_lc << 7) | 16'(m_la << 6)
        | 16'(evt_status << 4) | 16'(m_en << 3) | 16'(m_co << 2) | 16'(m_pol << 1) | 16'(m_mode);
      case (m_ptr)
         0: return 16'h007F;
         1: return c;
         2: return m_hi;
         3: return m_lo;
         4: return m_cr;
         5: return m_temp;
         6: return 16'h1B09;
         default: return 16'h2230;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [15:0] d;
      bit locked;
      if (!rst_n) begin
         m_ptr = 0; m_hyst = 0; m_shdn = 0; m_lc = 0; m_la = 0; m_en = 0;
         m_co = 0; m_pol = 0; m_mode = 0; m_clr = 0;
         m_hi = 0; m_lo = 0; m_cr = 0; m_temp = 0;
      end else begin
         d = wr_data;
         m_clr = 0;
         if (conv_valid && !m_shdn) m_temp = conv_word;
         if (wr_en) begin
            case (m_ptr)
               1: begin
                  locked = m_lc | m_la;
                  m_clr = d[5];
                  m_co = m_la ? (m_co & d[2]) : d[2];
                  if (!locked) begin
                     m_hyst = int'(d[10:9]); m_shdn = d[8];
                     m_en = d[3]; m_pol = d[1]; m_mode = d[0];
                  end else begin
                     m_shdn = m_shdn & d[8];
                  end
                  m_lc = m_lc | d[7];
                  m_la = m_la | d[6];
               end
               2: if (!m_la) m_hi = d;
               3: if (!m_la) m_lo = d;
               4: if (!m_lc) m_cr = d;
               default: ;
            endcase
         end
         if (ptr_load) m_ptr = int'(ptr_in);
      end
      #5;
      if (!done) begin
         chk("R11 rd_data vs model", rd_data, model_rd());
         chk("R7 hyst_sel", {14'd0, hyst_sel}, 16'(m_hyst));
         chk("R8 shdn", {15'd0, shdn}, {15'd0, m_shdn});
         chk("R7 enable/pol/mode", {13'd0, evt_enable, evt_pol, evt_mode}, {13'd0, m_en, m_pol, m_mode});
         chk("R9 crit_only", {15'd0, crit_only}, {15'd0, m_co});
         chk("R4 evt_clear", {15'd0, evt_clear}, {15'd0, m_clr});
         chk("R6 lim_high", lim_high, m_hi);
         chk("R6 lim_low", lim_low, m_lo);
         chk("R6 lim_crit", lim_crit, m_cr);
         chk("R10 temp_word", temp_word, m_temp);
      end
   end

   task automatic sel(int a);
      @(negedge clk); ptr_load = 1'b1; ptr_in = 3'(a);
      @(negedge clk); ptr_load = 1'b0;
   endtask

   task automatic wr(int a, logic [15:0] v);
      sel(a);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic conv(logic [15:0] v);
      @(negedge clk); conv_valid = 1'b1; conv_word = v;
      @(negedge clk); conv_valid = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values and pointer at capability
      chk("R1 capability after reset", rd_data, 16'h007F);
      sel(1); chk("R1 config reset", rd_data, 16'h0000);
      sel(4); chk("R1 critical limit reset", rd_data, 16'h0000);
      sel(6); chk("R1 manufacturer", rd_data, 16'h1B09);
      sel(7); chk("R1 device/revision", rd_data, 16'h2230);

      // R2: read-only addresses ignore writes
      wr(0, 16'hFFFF); chk("R2 capability write ignored", rd_data, 16'h007F);
      wr(6, 16'h0000); chk("R2 manufacturer write ignored", rd_data, 16'h1B09);
      wr(7, 16'h0000); chk("R2 device write ignored", rd_data, 16'h2230);
      conv(16'h0123);
      sel(5); chk("R10 temperature loaded", rd_data, 16'h0123);
      wr(5, 16'hAAAA); chk("R2 temperature write ignored", rd_data, 16'h0123);

      // R3, R4: reserved bits and clear pulse
      wr(1, 16'hF82F);
      chk("R3 reserved bits read zero", rd_data, 16'h000F);
      chk("R4 clear pulse high", {15'd0, evt_clear}, 16'h0001);
      @(negedge clk);
      chk("R4 clear pulse one cycle", {15'd0, evt_clear}, 16'h0000);
      evt_status = 1'b1; #1;
      chk("R3 status bit follows input", rd_data, 16'h001F);
      evt_status = 1'b0;

      // R6: unlocked limit writes, R11 pointer selection
      wr(2, 16'h0190); wr(3, 16'hFF80); wr(4, 16'h0200);
      sel(3); chk("R11 low limit selected", rd_data, 16'hFF80);

      // R10: shutdown freezes temperature
      wr(1, 16'h0100); conv(16'h0456);
      sel(5); chk("R10 frozen in shutdown", rd_data, 16'h0123);
      wr(1, 16'h0000); conv(16'h0456);
      sel(5); chk("R10 updates when active", rd_data, 16'h0456);

      // alarm lock set together with fields
      wr(1, 16'h0544); chk("R5 alarm lock set", rd_data, 16'h0544);
      wr(1, 16'h0000); chk("R8 R9 clear allowed under lock, R5 lock kept", rd_data, 16'h0440);
      wr(1, 16'h070F); chk("R7 R8 R9 locked fields refuse", rd_data, 16'h0440);
      wr(2, 16'h1111); chk("R6 high limit locked", rd_data, 16'h0190);
      wr(4, 16'h0300); chk("R6 critical writable without its lock", rd_data, 16'h0300);
      wr(1, 16'h0080); chk("R5 critical lock set", rd_data, 16'h04C0);
      wr(4, 16'h0400); chk("R6 critical limit locked", rd_data, 16'h0300);
      wr(1, 16'h0000); chk("R5 locks stay set", rd_data, 16'h04C0);

      // reset clears locks
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      chk("R1 pointer back to capability", rd_data, 16'h007F);
      sel(1); chk("R5 reset clears locks", rd_data, 16'h0000);

      // critical lock alone
      wr(1, 16'h0080);
      wr(1, 16'h0100); chk("R8 shutdown refused under critical lock", rd_data, 16'h0080);
      wr(1, 16'h0004); chk("R9 critical-only settable under critical lock only", rd_data, 16'h0084);
      wr(2, 16'h0055); chk("R6 alarm limit writable under critical lock", rd_data, 16'h0055);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule